// File: doc/BRIEF.md
# Quad Serial Command Receiver

This block sits behind the chip-select-framed serial host link of a storage device and turns the incoming instruction stream into decoded commands. Each frame opens when chip select goes low. On every rising clock edge inside the frame the block samples either one bit on line 0 (single-line mode) or a nibble on all four lines (four-line mode), most significant part first. It assembles the opcode byte and, for the opcodes that carry one, a 24-bit address and a dummy byte. It then raises a one-cycle strobe with the opcode and the collected address.

The block also keeps the current bus width. A mode-entry command switches it to four-line transfers and a mode-exit command switches it back. A frame that chip select closes before its last nibble has no effect. A two-step guard lets the device reset command act only when the reset-enable command came directly before it. Everything after the command header, such as data bytes, read drivers and the array, belongs to downstream logic. That logic uses the strobe to take over.

Top module: `quad_cmd_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `quad_mode`, `cmd_stb` and `rst_pulse` are 0. The block powers up in single-line mode.
- R2: In single-line mode a byte is taken from `sio[0]` over eight consecutive sampled edges, most significant bit first. `sio[3:1]` is ignored. For an opcode without address, `cmd_stb` is high in the cycle that follows the edge that sampled the eighth bit.
- R3: In four-line mode a byte is taken over two sampled edges, with the high nibble first and `sio[3]` as the most significant line.
- R4: A completed 38h switches `quad_mode` to 1 and a completed FFh switches it to 0. The change becomes visible together with that command's strobe. `quad_mode` changes at no other time, except through R7.
- R5: Opcodes 03h, 0Bh, 20h, D8h and 02h are followed by three address bytes, most significant first. 0Bh is also followed by one dummy byte. The strobe appears only after the last of these bytes, with `cmd_addr` holding the address.
- R6: If chip select rises before the last nibble or bit of the header, the frame produces no strobe and no mode change. The next frame is assembled from scratch.
- R7: A completed 99h raises `rst_pulse` together with its strobe only when the previous completed command was 66h and no frame has been dropped since then. A reset that fires also returns `quad_mode` to 0.
- R8: Any completed command other than 66h between 66h and 99h disarms the reset. This includes 00h, which otherwise changes nothing, not even `quad_mode`.
- R9: A frame after 66h that chip select ends early (R6) also disarms the reset.
- R10: Once the header of a frame is complete, further edges while chip select stays low are ignored. There is exactly one strobe per frame.
- R11: `cmd_stb` is a one-cycle pulse. `cmd_op` carries the opcode while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select that frames each instruction |
| sio | input | 4 | Serial data lines; line 0 only in single-line mode |
| cmd_stb | output | 1 | One-cycle pulse: a complete header was received |
| cmd_op | output | 8 | Opcode of the last completed header |
| cmd_addr | output | 24 | Address collected for the last address-carrying opcode |
| quad_mode | output | 1 | 1 when four-line transfers are in use |
| rst_pulse | output | 1 | One-cycle device reset request, coincident with a 99h strobe |

## Verification
A wrong bit counter or a bad width flag shows as a strobe one or more cycles early or late. It also shows as an opcode that is shifted or mixed from lines 1 to 3. Both are visible on the first command after the fault, so the bench checks the strobe in the exact cycle the requirements predict. A stale reset-enable flag only appears at the next 99h. For that reason each way of disarming is followed at once by a 99h and a check of `rst_pulse`. A bad phase register shows as an extra strobe from data bytes, or as a missing strobe after a dummy byte.

// File: rtl/quad_cmd_pkg.sv
package quad_cmd_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OP_NOP      = 8'h00;
    localparam logic [OPC_W-1:0] OP_RST_ARM  = 8'h66;
    localparam logic [OPC_W-1:0] OP_RST_GO   = 8'h99;
    localparam logic [OPC_W-1:0] OP_WIDE_ON  = 8'h38;
    localparam logic [OPC_W-1:0] OP_WIDE_OFF = 8'hFF;
    localparam logic [OPC_W-1:0] OP_RD       = 8'h03;
    localparam logic [OPC_W-1:0] OP_RD_FAST  = 8'h0B;
    localparam logic [OPC_W-1:0] OP_ER_SECT  = 8'h20;
    localparam logic [OPC_W-1:0] OP_ER_BLK   = 8'hD8;
    localparam logic [OPC_W-1:0] OP_PROG     = 8'h02;

    typedef enum logic [1:0] {
        PH_OP,
        PH_ADR,
        PH_DMY,
        PH_HOLD
    } phase_e;

    function automatic logic op_has_addr(input logic [OPC_W-1:0] op);
        return (op == OP_RD) || (op == OP_RD_FAST) || (op == OP_ER_SECT) ||
               (op == OP_ER_BLK) || (op == OP_PROG);
    endfunction

    function automatic logic op_has_dummy(input logic [OPC_W-1:0] op);
        return op == OP_RD_FAST;
    endfunction

endpackage

// File: rtl/quad_cmd_shifter.sv
module quad_cmd_shifter #(
    parameter int BYTE_W = 8,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              wide,
    input  logic [LINES-1:0]  sio,
    output logic [BYTE_W-1:0] byte_o,
    output logic              done_o
);
    localparam int NARROW_UNITS = BYTE_W;
    localparam int WIDE_UNITS   = BYTE_W / LINES;
    localparam int CNT_W        = $clog2(NARROW_UNITS);

    typedef struct packed {
        logic [BYTE_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } sh_t;

    sh_t q, d;
    logic [BYTE_W-1:0] shifted;
    logic [CNT_W-1:0]  last_cnt;

    always_comb begin
        if (wide) begin
            shifted  = {q.sr[BYTE_W-LINES-1:0], sio};
            last_cnt = CNT_W'(WIDE_UNITS - 1);
        end else begin
            shifted  = {q.sr[BYTE_W-2:0], sio[0]};
            last_cnt = CNT_W'(NARROW_UNITS - 1);
        end
        done_o = en && (q.cnt == last_cnt);
        byte_o = shifted;

        d = q;
        if (clr) begin
            d.sr  = '0;
            d.cnt = '0;
        end else if (en) begin
            d.sr  = shifted;
            d.cnt = done_o ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/quad_cmd_rst_guard.sv
module quad_cmd_rst_guard
    import quad_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_done,
    input  logic [OPC_W-1:0] op,
    input  logic             frame_end,
    input  logic             keep,
    output logic             fire_o
);
    typedef struct packed {
        logic armed;
    } gd_t;

    gd_t q, d;

    always_comb begin
        fire_o = op_done && (op == OP_RST_GO) && q.armed;
        d = q;
        if (op_done)                 d.armed = (op == OP_RST_ARM);
        else if (frame_end && !keep) d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/quad_cmd_rx.sv
module quad_cmd_rx
    import quad_cmd_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int LINES      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic [LINES-1:0]        sio,
    output logic                    cmd_stb,
    output logic [OPC_W-1:0]        cmd_op,
    output logic [ADDR_BYTES*8-1:0] cmd_addr,
    output logic                    quad_mode,
    output logic                    rst_pulse
);
    localparam int ADDR_W = ADDR_BYTES * OPC_W;
    localparam int NB_W   = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        phase_e             ph;
        logic [OPC_W-1:0]   op;
        logic [ADDR_W-1:0]  addr;
        logic [NB_W-1:0]    nb;
        logic               wide;
        logic               stb;
        logic               rstp;
        logic               cs_prev;
    } rx_t;

    rx_t q, d;

    logic             s_en;
    logic             frame_end;
    logic             keep;
    logic [OPC_W-1:0] rx_byte;
    logic             rx_done;
    logic             complete;
    logic [OPC_W-1:0] cop;
    logic             fire;

    assign s_en      = !cs_n && (q.ph != PH_HOLD);
    assign frame_end = cs_n && !q.cs_prev;
    assign keep      = (q.ph == PH_HOLD) && (q.op == OP_RST_ARM);

    quad_cmd_shifter #(
        .BYTE_W (OPC_W),
        .LINES  (LINES)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cs_n),
        .en     (s_en),
        .wide   (q.wide),
        .sio    (sio),
        .byte_o (rx_byte),
        .done_o (rx_done)
    );

    quad_cmd_rst_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_done   (complete),
        .op        (cop),
        .frame_end (frame_end),
        .keep      (keep),
        .fire_o    (fire)
    );

    always_comb begin
        complete  = 1'b0;
        cop       = (q.ph == PH_OP) ? rx_byte : q.op;

        d         = q;
        d.stb     = 1'b0;
        d.rstp    = 1'b0;
        d.cs_prev = cs_n;

        if (cs_n) begin
            d.ph = PH_OP;
            d.nb = '0;
        end else if (rx_done) begin
            case (q.ph)
                PH_OP: begin
                    d.op = rx_byte;
                    if (op_has_addr(rx_byte)) begin
                        d.ph = PH_ADR;
                        d.nb = '0;
                    end else begin
                        complete = 1'b1;
                    end
                end
                PH_ADR: begin
                    d.addr = (q.addr << OPC_W) | ADDR_W'(rx_byte);
                    if (q.nb == NB_W'(ADDR_BYTES - 1)) begin
                        if (op_has_dummy(q.op)) d.ph = PH_DMY;
                        else                    complete = 1'b1;
                    end else begin
                        d.nb = q.nb + 1'b1;
                    end
                end
                PH_DMY:  complete = 1'b1;
                default: ;
            endcase
        end

        if (complete) begin
            d.stb = 1'b1;
            d.ph  = PH_HOLD;
            if (cop == OP_WIDE_ON)  d.wide = 1'b1;
            if (cop == OP_WIDE_OFF) d.wide = 1'b0;
            if (fire) begin
                d.wide = 1'b0;
                d.rstp = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.ph      <= PH_OP;
            q.cs_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cmd_stb   = q.stb;
    assign cmd_op    = q.op;
    assign cmd_addr  = q.addr;
    assign quad_mode = q.wide;
    assign rst_pulse = q.rstp;

endmodule

// File: rtl/quad_cmd_rx_chk.sv
module quad_cmd_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       cmd_stb,
    input logic [7:0] cmd_op,
    input logic       quad_mode,
    input logic       rst_pulse
);
    // R11
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    // R7
    rst_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> (cmd_stb && cmd_op == 8'h99 && !quad_mode));

    // R4
    wide_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quad_mode) |-> (cmd_stb && cmd_op == 8'h38));

    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |-> $stable(quad_mode));

    // R8
    nop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_op == 8'h00) |-> $stable(quad_mode));

    // R2
    stb_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> ($past(cs_n) == 1'b0));

endmodule

bind quad_cmd_rx quad_cmd_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cmd_stb   (cmd_stb),
    .cmd_op    (cmd_op),
    .quad_mode (quad_mode),
    .rst_pulse (rst_pulse)
);

// File: tb/quad_cmd_rx_bench.sv
module quad_cmd_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n;
    logic [3:0]  sio;
    logic        cmd_stb;
    logic [7:0]  cmd_op;
    logic [23:0] cmd_addr;
    logic        quad_mode;
    logic        rst_pulse;

    always #4 clk = ~clk;

    quad_cmd_rx u_quad_cmd_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sio       (sio),
        .cmd_stb   (cmd_stb),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .quad_mode (quad_mode),
        .rst_pulse (rst_pulse)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          stb_cnt = 0;
    int          rst_cnt = 0;
    logic [7:0]  last_op = '0;
    logic [23:0] last_addr = '0;
    bit          bq = 1'b0;

    always @(negedge clk) begin
        if (rst_n && cmd_stb) begin
            stb_cnt++;
            last_op   = cmd_op;
            last_addr = cmd_addr;
            if (rst_pulse) rst_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic unit(input logic [3:0] v);
        cs_n = 1'b0;
        sio  = v;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        if (bq) begin
            unit(b[7:4]);
            unit(b[3:0]);
        end else begin
            for (int i = 7; i >= 0; i--) unit({3'b101, b[i]});
        end
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        sio  = 4'h0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        send_byte(op);
        end_frame();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cs_n  = 1'b1;
        sio   = 4'h0;
        repeat (3) @(negedge clk);
        chk("R1 mode", quad_mode, 0);
        chk("R1 stb", cmd_stb, 0);
        chk("R1 rst", rst_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode after release", quad_mode, 0);
    endtask

    task automatic t_single_timing();
        send_byte(8'h06);
        chk("R2 strobe after eighth bit", cmd_stb, 1);
        chk("R2 opcode", cmd_op, 8'h06);
        @(negedge clk);
        chk("R11 strobe one cycle", cmd_stb, 0);
        end_frame();
    endtask

    task automatic t_addr_single();
        int s0;
        s0 = stb_cnt;
        send_byte(8'h03);
        send_byte(8'h12);
        send_byte(8'h34);
        chk("R5 no strobe mid address", cmd_stb, 0);
        send_byte(8'h56);
        chk("R5 strobe after address", cmd_stb, 1);
        end_frame();
        chk("R5 one strobe", stb_cnt - s0, 1);
        chk("R5 opcode", last_op, 8'h03);
        chk("R5 address", last_addr, 24'h123456);
    endtask

    task automatic t_enter_quad();
        cmd(8'h38);
        chk("R4 quad on", quad_mode, 1);
        chk("R4 op", last_op, 8'h38);
        bq = 1'b1;
    endtask

    task automatic t_quad_addr();
        send_byte(8'h20);
        send_byte(8'hAB);
        send_byte(8'hCD);
        send_byte(8'hEF);
        chk("R3 strobe after two-edge bytes", cmd_stb, 1);
        end_frame();
        chk("R3 opcode", last_op, 8'h20);
        chk("R3 address", last_addr, 24'hABCDEF);
        send_byte(8'h0B);
        send_byte(8'h01);
        send_byte(8'h02);
        send_byte(8'h03);
        chk("R5 waits for dummy", cmd_stb, 0);
        send_byte(8'h5A);
        chk("R5 strobe after dummy", cmd_stb, 1);
        chk("R5 fast opcode", cmd_op, 8'h0B);
        chk("R5 fast address", cmd_addr, 24'h010203);
        end_frame();
    endtask

    task automatic t_hold();
        int s0;
        s0 = stb_cnt;
        send_byte(8'h02);
        send_byte(8'h00);
        send_byte(8'h10);
        send_byte(8'h20);
        send_byte(8'h38);
        send_byte(8'hFF);
        send_byte(8'h20);
        end_frame();
        chk("R10 one strobe per frame", stb_cnt - s0, 1);
        chk("R10 data ignored", last_op, 8'h02);
        chk("R10 mode unchanged by data", quad_mode, 1);
    endtask

    task automatic t_abort();
        int s0;
        s0 = stb_cnt;
        unit(4'hF);
        end_frame();
        chk("R6 no strobe on early rise", stb_cnt - s0, 0);
        chk("R6 no mode change", quad_mode, 1);
        cmd(8'h05);
        chk("R6 fresh assembly", last_op, 8'h05);
    endtask

    task automatic t_reset_seq();
        int r0;
        r0 = rst_cnt;
        cmd(8'h66);
        cmd(8'h99);
        chk("R7 reset fires", rst_cnt - r0, 1);
        chk("R7 back to single", quad_mode, 0);
        bq = 1'b0;
    endtask

    task automatic t_nop_disarm();
        int r0;
        t_enter_quad();
        r0 = rst_cnt;
        cmd(8'h66);
        cmd(8'h00);
        chk("R8 nop keeps mode", quad_mode, 1);
        cmd(8'h99);
        chk("R8 nop disarms", rst_cnt - r0, 0);
        chk("R8 mode kept", quad_mode, 1);
        cmd(8'h66);
        cmd(8'h06);
        cmd(8'h99);
        chk("R8 other cmd disarms", rst_cnt - r0, 0);
    endtask

    task automatic t_abort_disarm();
        int r0;
        r0 = rst_cnt;
        cmd(8'h66);
        unit(4'h9);
        end_frame();
        cmd(8'h99);
        chk("R9 dropped frame disarms", rst_cnt - r0, 0);
        cmd(8'h66);
        cmd(8'h99);
        chk("R7 rearmed reset fires", rst_cnt - r0, 1);
        bq = 1'b0;
    endtask

    task automatic t_exit_quad();
        t_enter_quad();
        cmd(8'hFF);
        chk("R4 quad off", quad_mode, 0);
        bq = 1'b0;
        cmd(8'h9F);
        chk("R4 single after exit", last_op, 8'h9F);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 50000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_single_timing();
        t_addr_single();
        t_enter_quad();
        t_quad_addr();
        t_hold();
        t_abort();
        t_reset_seq();
        t_nop_disarm();
        t_abort_disarm();
        t_exit_quad();
        summary();
        $finish;
    end

endmodule